// File: doc/BRIEF.md
# Tagged Memory Version Checker

This block keeps a small array of 4-bit version tags, one for each 64-byte line of an internal data RAM, and checks each load and store against the tag of the line it touches. The expected version comes from the top four bits of the 64-bit pointer. Checking only takes place when two enables are both set: a detection enable for the issuing thread and a tag enable for the page. When checking is off, the access goes through without any test.

A load whose pointer version differs from the line tag returns no data. It raises a trap in the same cycle as its response. The trap reports the stored version and the faulting address with its tag bits normalized. A store that mismatches is dropped without any trap.

A separate tag-access port, selected by an alternate-space code, lets software read a line's tag, write it, or write it and zero the whole line in one operation. An error write-back input forces a line's tag to the reserved value 14, which is why normal software only uses versions up to 13.

Top module: `version_tag_checker`

## Requirements
- R1: After reset every line tag reads as 0 and every data word reads as 0, and all response outputs are low.
- R2: A tag write (tagWrite=1) with tagSpace 0x90 or 0x92 on an enabled page stores tagVersion for the addressed line. A tag read (tagWrite=0) with either code returns the line's current version on tagRspVersion, with tagRspValid high one cycle after the request. Any other tagSpace code is ignored and gives no response.
- R3: A pointer version of 0 or 15 in reqAddr[63:60] matches any line tag, and the access never traps.
- R4: When reqThreadDetEn or reqPageTagEn is low, a load returns the stored data and a store writes it, whatever the versions.
- R5: A checked load whose pointer version differs from the line tag sets rspTrap for exactly one cycle, together with rspValid, one cycle after the request. It returns rspRdata = 0 and reports the stored line tag on trapVersion.
- R6: trapAddr is the request address with bits 63:60 replaced by copies of bit 59.
- R7: A load that passes returns, one cycle after the request, the last 64-bit word stored at that address (line from bits 9:6, word from bits 5:3).
- R8: A checked store whose version mismatches leaves the data word unchanged and raises no trap, but still gets rspValid.
- R9: A tag write with tagSpace 0x92 also clears all eight words of the line in the same cycle.
- R10: An error write-back (errValid) sets the addressed line's tag to 14, whatever it held before.
- R11: A tag write or block-init with tagPageEn low changes neither the tag nor the data.
- R12: A tag applies to a whole 64-byte line: address bits 5:0 do not select the tag, and neighbouring lines keep their own tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request valid |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | 64 | Tagged pointer; bits 63:60 hold the version |
| reqWdata | input | 64 | Store data |
| reqPageTagEn | input | 1 | Tag checking enabled for the page |
| reqThreadDetEn | input | 1 | Tag checking enabled for the thread |
| rspValid | output | 1 | Response for the access of the previous cycle |
| rspRdata | output | 64 | Load data, 0 on trap or store |
| rspTrap | output | 1 | Precise load-mismatch trap |
| trapAddr | output | 64 | Normalized faulting address |
| trapVersion | output | 4 | Stored tag of the faulting line |
| tagValid | input | 1 | Tag-access request valid |
| tagWrite | input | 1 | 1 = set tag, 0 = read tag |
| tagSpace | input | 8 | Alternate-space code: 0x90 plain, 0x92 block-init |
| tagAddr | input | 64 | Address of the line to access |
| tagVersion | input | 4 | Version to write |
| tagPageEn | input | 1 | Page tag enable for the tag access |
| tagRspValid | output | 1 | Tag read response valid |
| tagRspVersion | output | 4 | Tag read result |
| errValid | input | 1 | Uncorrectable-error write-back event |
| errAddr | input | 64 | Address of the line being written back |

## Verification
A wrong entry in the tag array does not show until a later access uses that line. It then appears as a false trap or a missing trap, one cycle after the first checked load with a non-universal version, or as a wrong value on the next tag read. A corrupted data word appears only on the next passing load of that word. A dropped or extra store is therefore seen through a read-back, not at the time of the store. Because of this, the bench keeps a full shadow of tags and data and reads lines back after tag writes, block-inits, disabled-page writes and error write-backs.

// File: rtl/tagchk_pkg.sv
`timescale 1ns/1ps
package tagchk_pkg;

  localparam int unsigned DefAddrW     = 64;
  localparam int unsigned DefDataW     = 64;
  localparam int unsigned DefTagW      = 4;
  localparam int unsigned DefLineBytes = 64;
  localparam int unsigned DefNumLines  = 16;

  localparam logic [7:0] SpaceTagPlain = 8'h90;
  localparam logic [7:0] SpaceTagBlock = 8'h92;

  // Control-to-datapath strobes, at most one load/store outcome per cycle.
  typedef struct packed {
    logic loadPass;
    logic loadTrap;
    logic storeWrite;
    logic storeDrop;
    logic tagSet;
    logic tagGet;
    logic blkZero;
    logic errForce;
  } tagchk_strobe_t;

endpackage

// File: rtl/tagchk_ctrl.sv
`timescale 1ns/1ps
module tagchk_ctrl
  import tagchk_pkg::*;
#(
  parameter int unsigned TAG_W = DefTagW
) (
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [TAG_W-1:0] ptrVer,
  input  logic             reqPageTagEn,
  input  logic             reqThreadDetEn,
  input  logic [TAG_W-1:0] storedVer,
  input  logic             tagValid,
  input  logic             tagWrite,
  input  logic [7:0]       tagSpace,
  input  logic             tagPageEn,
  input  logic             errValid,
  output tagchk_strobe_t   strobe
);

  logic checkOn;
  logic wildVer;
  logic mismatch;
  logic isPlain;
  logic isBlock;
  logic spaceOk;
  logic isLoad;
  logic isStore;

  always_comb begin
    checkOn  = reqThreadDetEn && reqPageTagEn;
    wildVer  = (ptrVer == '0) || (ptrVer == '1);
    mismatch = checkOn && !wildVer && (ptrVer != storedVer);
    isLoad   = reqValid && !reqWrite;
    isStore  = reqValid && reqWrite;
    isPlain  = (tagSpace == SpaceTagPlain);
    isBlock  = (tagSpace == SpaceTagBlock);
    spaceOk  = isPlain || isBlock;
  end

  always_comb begin
    strobe            = '0;
    strobe.loadPass   = isLoad && !mismatch;
    strobe.loadTrap   = isLoad && mismatch;
    strobe.storeWrite = isStore && !mismatch;
    strobe.storeDrop  = isStore && mismatch;
    strobe.tagSet     = tagValid && tagWrite && tagPageEn && spaceOk;
    strobe.blkZero    = tagValid && tagWrite && tagPageEn && isBlock;
    strobe.tagGet     = tagValid && !tagWrite && spaceOk;
    strobe.errForce   = errValid;
  end

endmodule

// File: rtl/tagchk_dpath.sv
`timescale 1ns/1ps
module tagchk_dpath
  import tagchk_pkg::*;
#(
  parameter int unsigned ADDR_W     = DefAddrW,
  parameter int unsigned DATA_W     = DefDataW,
  parameter int unsigned TAG_W      = DefTagW,
  parameter int unsigned LINE_BYTES = DefLineBytes,
  parameter int unsigned NUM_LINES  = DefNumLines
) (
  input  logic              clk,
  input  logic              rstN,
  input  tagchk_strobe_t    strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [ADDR_W-1:0] tagAddr,
  input  logic [TAG_W-1:0]  tagVersion,
  input  logic [ADDR_W-1:0] errAddr,
  output logic [TAG_W-1:0]  storedVer,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspTrap,
  output logic [ADDR_W-1:0] trapAddr,
  output logic [TAG_W-1:0]  trapVersion,
  output logic              tagRspValid,
  output logic [TAG_W-1:0]  tagRspVersion
);

  localparam int unsigned WordBytes    = DATA_W / 8;
  localparam int unsigned WordOff      = $clog2(WordBytes);
  localparam int unsigned LineOff      = $clog2(LINE_BYTES);
  localparam int unsigned WordsPerLine = LINE_BYTES / WordBytes;
  localparam int unsigned WordIdxW     = $clog2(WordsPerLine);
  localparam int unsigned LineIdxW     = $clog2(NUM_LINES);
  localparam int unsigned MemWords     = NUM_LINES * WordsPerLine;
  localparam int unsigned MemIdxW      = LineIdxW + WordIdxW;
  localparam int unsigned SignBit      = ADDR_W - TAG_W - 1;
  localparam logic [TAG_W-1:0] ReservedVer = TAG_W'((1 << TAG_W) - 2);

  logic [TAG_W-1:0]  tagMem  [NUM_LINES];
  logic [DATA_W-1:0] dataMem [MemWords];

  logic [LineIdxW-1:0] reqLine;
  logic [LineIdxW-1:0] tagLine;
  logic [LineIdxW-1:0] errLine;
  logic [MemIdxW-1:0]  reqIdx;
  logic [ADDR_W-1:0]   normAddr;
  logic                unusedAddrBits;

  assign reqLine  = reqAddr[LineOff +: LineIdxW];
  assign tagLine  = tagAddr[LineOff +: LineIdxW];
  assign errLine  = errAddr[LineOff +: LineIdxW];
  assign reqIdx   = {reqLine, reqAddr[WordOff +: WordIdxW]};
  assign normAddr = {{TAG_W{reqAddr[SignBit]}}, reqAddr[SignBit:0]};
  assign unusedAddrBits = ^{tagAddr, errAddr};

  assign storedVer = tagMem[reqLine];

  // Storage: data writes first, block-init clears after; error write-back
  // overrides a tag set aimed at the same line.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LINES; i++) tagMem[i] <= '0;
      for (int j = 0; j < MemWords; j++) dataMem[j] <= '0;
    end else begin
      if (strobe.storeWrite) dataMem[reqIdx] <= reqWdata;
      if (strobe.blkZero) begin
        for (int w = 0; w < WordsPerLine; w++)
          dataMem[{tagLine, WordIdxW'(w)}] <= '0;
      end
      if (strobe.tagSet)   tagMem[tagLine] <= tagVersion;
      if (strobe.errForce) tagMem[errLine] <= ReservedVer;
    end
  end

  // Registered responses, one cycle after the request.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid      <= 1'b0;
      rspRdata      <= '0;
      rspTrap       <= 1'b0;
      trapAddr      <= '0;
      trapVersion   <= '0;
      tagRspValid   <= 1'b0;
      tagRspVersion <= '0;
    end else begin
      rspValid      <= strobe.loadPass || strobe.loadTrap ||
                       strobe.storeWrite || strobe.storeDrop;
      rspRdata      <= strobe.loadPass ? dataMem[reqIdx] : '0;
      rspTrap       <= strobe.loadTrap;
      trapAddr      <= strobe.loadTrap ? normAddr : '0;
      trapVersion   <= strobe.loadTrap ? storedVer : '0;
      tagRspValid   <= strobe.tagGet;
      tagRspVersion <= strobe.tagGet ? tagMem[tagLine] : '0;
    end
  end

  p_err_tag_reserved_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.errForce |=> tagMem[$past(errLine)] == ReservedVer);

  p_blk_first_word_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.blkZero |=> dataMem[{$past(tagLine), WordIdxW'(0)}] == '0);

  p_blk_last_word_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.blkZero |=> dataMem[{$past(tagLine), WordIdxW'(WordsPerLine - 1)}] == '0);

endmodule

// File: rtl/version_tag_checker.sv
`timescale 1ns/1ps
module version_tag_checker
  import tagchk_pkg::*;
#(
  parameter int unsigned ADDR_W     = DefAddrW,
  parameter int unsigned DATA_W     = DefDataW,
  parameter int unsigned TAG_W      = DefTagW,
  parameter int unsigned LINE_BYTES = DefLineBytes,
  parameter int unsigned NUM_LINES  = DefNumLines
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqPageTagEn,
  input  logic              reqThreadDetEn,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspTrap,
  output logic [ADDR_W-1:0] trapAddr,
  output logic [TAG_W-1:0]  trapVersion,
  input  logic              tagValid,
  input  logic              tagWrite,
  input  logic [7:0]        tagSpace,
  input  logic [ADDR_W-1:0] tagAddr,
  input  logic [TAG_W-1:0]  tagVersion,
  input  logic              tagPageEn,
  output logic              tagRspValid,
  output logic [TAG_W-1:0]  tagRspVersion,
  input  logic              errValid,
  input  logic [ADDR_W-1:0] errAddr
);

  localparam int unsigned SignBit = ADDR_W - TAG_W - 1;

  tagchk_strobe_t   strobe;
  logic [TAG_W-1:0] storedVer;
  logic [TAG_W-1:0] ptrVer;

  assign ptrVer = reqAddr[ADDR_W-1 -: TAG_W];

  tagchk_ctrl #(.TAG_W(TAG_W)) i_ctrl (
    .reqValid       (reqValid),
    .reqWrite       (reqWrite),
    .ptrVer         (ptrVer),
    .reqPageTagEn   (reqPageTagEn),
    .reqThreadDetEn (reqThreadDetEn),
    .storedVer      (storedVer),
    .tagValid       (tagValid),
    .tagWrite       (tagWrite),
    .tagSpace       (tagSpace),
    .tagPageEn      (tagPageEn),
    .errValid       (errValid),
    .strobe         (strobe)
  );

  tagchk_dpath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .TAG_W      (TAG_W),
    .LINE_BYTES (LINE_BYTES),
    .NUM_LINES  (NUM_LINES)
  ) i_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .reqAddr       (reqAddr),
    .reqWdata      (reqWdata),
    .tagAddr       (tagAddr),
    .tagVersion    (tagVersion),
    .errAddr       (errAddr),
    .storedVer     (storedVer),
    .rspValid      (rspValid),
    .rspRdata      (rspRdata),
    .rspTrap       (rspTrap),
    .trapAddr      (trapAddr),
    .trapVersion   (trapVersion),
    .tagRspValid   (tagRspValid),
    .tagRspVersion (tagRspVersion)
  );

  p_wild_never_traps_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && ((ptrVer == '0) || (ptrVer == '1))) |=> !rspTrap);

  p_unchecked_never_traps_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !(reqPageTagEn && reqThreadDetEn)) |=> !rspTrap);

  p_store_never_traps_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=> (rspValid && !rspTrap));

  p_trap_with_empty_rsp_r5: assert property (@(posedge clk) disable iff (!rstN)
    rspTrap |-> (rspValid && rspRdata == '0));

  p_trap_addr_canonical_r6: assert property (@(posedge clk) disable iff (!rstN)
    rspTrap |-> (trapAddr[ADDR_W-1 -: TAG_W] == {TAG_W{trapAddr[SignBit]}}));

  p_tag_read_answers_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tagValid && !tagWrite && (tagSpace == SpaceTagPlain || tagSpace == SpaceTagBlock))
      |=> tagRspValid);

endmodule

// File: tb/test_version_tag_checker.sv
`timescale 1ns/1ps
module test_version_tag_checker;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWrite, reqPageTagEn, reqThreadDetEn;
  logic [63:0] reqAddr, reqWdata;
  logic        rspValid, rspTrap;
  logic [63:0] rspRdata, trapAddr;
  logic [3:0]  trapVersion;
  logic        tagValid, tagWrite, tagPageEn;
  logic [7:0]  tagSpace;
  logic [63:0] tagAddr;
  logic [3:0]  tagVersion;
  logic        tagRspValid;
  logic [3:0]  tagRspVersion;
  logic        errValid;
  logic [63:0] errAddr;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  logic [3:0]  tagM  [16];
  logic [63:0] dataM [128];

  always #2.5 clk = ~clk;

  version_tag_checker i_version_tag_checker (.*);

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [3:0] v, input logic [3:0] line,
                                     input logic [2:0] word, input logic [49:0] hi,
                                     input logic [2:0] lo);
    return {v, hi, line, word, lo};
  endfunction

  function automatic logic [63:0] norm(input logic [63:0] a);
    return {{4{a[59]}}, a[59:0]};
  endfunction

  function automatic bit mism(input logic [63:0] a, input bit pe, input bit te);
    logic [3:0] v;
    v = a[63:60];
    return pe && te && (v != 4'd0) && (v != 4'd15) && (v != tagM[a[9:6]]);
  endfunction

  task automatic idle();
    reqValid = 0; reqWrite = 0; reqAddr = '0; reqWdata = '0;
    reqPageTagEn = 0; reqThreadDetEn = 0;
    tagValid = 0; tagWrite = 0; tagSpace = '0; tagAddr = '0; tagVersion = '0; tagPageEn = 0;
    errValid = 0; errAddr = '0;
  endtask

  task automatic access(input string rq, input bit wr, input logic [63:0] a,
                        input logic [63:0] wd, input bit pe, input bit te);
    bit          m;
    logic [6:0]  idx;
    m   = mism(a, pe, te);
    idx = {a[9:6], a[5:3]};
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = wd;
    reqPageTagEn = pe; reqThreadDetEn = te;
    @(negedge clk);
    idle();
    chk({rq, " rspValid"}, rspValid, 1);
    if (!wr) begin
      chk({rq, " trap flag"}, rspTrap, m);
      if (m) begin
        chk({rq, " R5 no data on trap"}, rspRdata, 0);
        chk({rq, " R6 trap address"}, trapAddr, norm(a));
        chk({rq, " R5 trap version"}, trapVersion, tagM[a[9:6]]);
      end else begin
        chk({rq, " R7 load data"}, rspRdata, dataM[idx]);
      end
    end else begin
      chk({rq, " R8 store no trap"}, rspTrap, 0);
      if (!m) dataM[idx] = wd;
    end
    @(negedge clk);
    chk({rq, " R5 trap one cycle"}, rspTrap, 0);
  endtask

  task automatic tagOp(input string rq, input bit wr, input logic [7:0] sp,
                       input logic [63:0] a, input logic [3:0] v, input bit pe);
    bit         ok;
    logic [3:0] line;
    logic [3:0] old;
    ok   = (sp == 8'h90) || (sp == 8'h92);
    line = a[9:6];
    old  = tagM[line];
    @(negedge clk);
    tagValid = 1; tagWrite = wr; tagSpace = sp; tagAddr = a; tagVersion = v; tagPageEn = pe;
    @(negedge clk);
    idle();
    if (wr) begin
      chk({rq, " R2 no response on write"}, tagRspValid, 0);
      if (ok && pe) begin
        tagM[line] = v;
        if (sp == 8'h92) for (int w = 0; w < 8; w++) dataM[{line, w[2:0]}] = '0;
      end
    end else begin
      chk({rq, " R2 read valid"}, tagRspValid, ok);
      if (ok) chk({rq, " R2 read version"}, tagRspVersion, old);
    end
  endtask

  task automatic errWb(input logic [63:0] a);
    @(negedge clk);
    errValid = 1; errAddr = a;
    @(negedge clk);
    idle();
    tagM[a[9:6]] = 4'd14;
  endtask

  task automatic readTag(input string rq, input logic [3:0] line);
    tagOp(rq, 0, 8'h90, mk(4'd0, line, 3'd0, 50'h0, 3'd0), 4'd0, 1);
  endtask

  initial begin
    idle();
    for (int i = 0; i < 16; i++) tagM[i] = '0;
    for (int i = 0; i < 128; i++) dataM[i] = '0;
    rstN = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    void'($urandom(32'd4242));

    // R1: reset state
    chk("R1 rspValid at reset", rspValid, 0);
    chk("R1 rspTrap at reset", rspTrap, 0);
    chk("R1 tagRspValid at reset", tagRspValid, 0);
    readTag("R1 line0", 4'd0);
    readTag("R1 line15", 4'd15);
    access("R1 data zero", 0, mk(4'd0, 4'd5, 3'd4, 50'h1234, 3'd0), 0, 1, 1);

    // R5/R6: mismatch against reset tag, both signs of bit 59
    access("R5 R6 positive", 0, mk(4'd7, 4'd2, 3'd0, 50'h0_1234_5678, 3'd2), 0, 1, 1);
    access("R5 R6 negative", 0, mk(4'd7, 4'd2, 3'd1, {1'b1, 49'h1_0000_ABCD}, 3'd5), 0, 1, 1);

    // R2, R7: set, read back, matching accesses
    tagOp("R2 set line2", 1, 8'h90, mk(4'd0, 4'd2, 3'd0, 50'h0, 3'd0), 4'd7, 1);
    readTag("R2 line2", 4'd2);
    access("R7 store v7", 1, mk(4'd7, 4'd2, 3'd3, 50'h0, 3'd0), 64'hA5A5_0000_1111_2222, 1, 1);
    access("R7 load v7", 0, mk(4'd7, 4'd2, 3'd3, 50'h0, 3'd0), 0, 1, 1);

    // R5, R8: mismatching load and store
    access("R5 load v8", 0, mk(4'd8, 4'd2, 3'd3, 50'h3, 3'd1), 0, 1, 1);
    access("R8 store v8 dropped", 1, mk(4'd8, 4'd2, 3'd3, 50'h0, 3'd0), 64'hDEAD, 1, 1);
    access("R8 readback", 0, mk(4'd7, 4'd2, 3'd3, 50'h0, 3'd0), 0, 1, 1);

    // R3: universal versions
    access("R3 load v0", 0, mk(4'd0, 4'd2, 3'd3, 50'h0, 3'd0), 0, 1, 1);
    access("R3 load v15", 0, mk(4'd15, 4'd2, 3'd3, 50'h0, 3'd0), 0, 1, 1);
    access("R3 store v15", 1, mk(4'd15, 4'd2, 3'd4, 50'h0, 3'd0), 64'h15, 1, 1);
    access("R3 readback", 0, mk(4'd7, 4'd2, 3'd4, 50'h0, 3'd0), 0, 1, 1);

    // R4: checking disabled
    access("R4 thread off load", 0, mk(4'd9, 4'd2, 3'd3, 50'h0, 3'd0), 0, 1, 0);
    access("R4 page off store", 1, mk(4'd9, 4'd2, 3'd5, 50'h0, 3'd0), 64'h4444, 0, 1);
    access("R4 readback", 0, mk(4'd7, 4'd2, 3'd5, 50'h0, 3'd0), 0, 1, 1);

    // R12: line granularity
    tagOp("R12 set via offset", 1, 8'h90, mk(4'd0, 4'd3, 3'd5, 50'h77, 3'd4), 4'd6, 1);
    access("R12 other word same line", 0, mk(4'd6, 4'd3, 3'd0, 50'h0, 3'd0), 0, 1, 1);
    access("R12 neighbour keeps tag", 0, mk(4'd6, 4'd4, 3'd0, 50'h0, 3'd0), 0, 1, 1);
    readTag("R12 line2 untouched", 4'd2);

    // R9: block-init
    tagOp("R9 block init", 1, 8'h92, mk(4'd0, 4'd2, 3'd6, 50'h0, 3'd7), 4'd9, 1);
    for (int w = 0; w < 8; w++)
      access("R9 cleared word", 0, mk(4'd9, 4'd2, w[2:0], 50'h0, 3'd0), 0, 1, 1);
    readTag("R9 tag", 4'd2);

    // R11: disabled-page tag writes ignored
    access("R11 seed store", 1, mk(4'd9, 4'd2, 3'd1, 50'h0, 3'd0), 64'h1111_2222, 1, 1);
    tagOp("R11 set ignored", 1, 8'h90, mk(4'd0, 4'd2, 3'd0, 50'h0, 3'd0), 4'd3, 0);
    tagOp("R11 blk ignored", 1, 8'h92, mk(4'd0, 4'd2, 3'd0, 50'h0, 3'd0), 4'd3, 0);
    readTag("R11 tag kept", 4'd2);
    access("R11 data kept", 0, mk(4'd9, 4'd2, 3'd1, 50'h0, 3'd0), 0, 1, 1);

    // R2: other alternate space ignored
    tagOp("R2 bad space write", 1, 8'h91, mk(4'd0, 4'd2, 3'd0, 50'h0, 3'd0), 4'd1, 1);
    tagOp("R2 bad space read", 0, 8'h91, mk(4'd0, 4'd2, 3'd0, 50'h0, 3'd0), 4'd0, 1);
    readTag("R2 after bad space", 4'd2);

    // R10: error write-back
    errWb(mk(4'd3, 4'd2, 3'd2, 50'h5, 3'd0));
    readTag("R10 tag forced", 4'd2);
    access("R10 old version traps", 0, mk(4'd9, 4'd2, 3'd1, 50'h0, 3'd0), 0, 1, 1);

    // Random mix
    for (int it = 0; it < 700; it++) begin
      logic [3:0]  line;
      logic [2:0]  word;
      logic [3:0]  v;
      logic [63:0] a;
      int          k;
      bit          pe, te;
      line = 4'($urandom_range(0, 15));
      word = 3'($urandom_range(0, 7));
      v    = ($urandom_range(0, 1) == 0) ? tagM[line] : 4'($urandom_range(0, 15));
      a    = mk(v, line, word, {$urandom, 18'($urandom)}, 3'($urandom_range(0, 7)));
      pe   = $urandom_range(0, 7) != 0;
      te   = $urandom_range(0, 7) != 0;
      k    = $urandom_range(0, 19);
      if (k < 7)       access("R5 R7 random load", 0, a, 0, pe, te);
      else if (k < 12) access("R8 R7 random store", 1, a, {$urandom, $urandom}, pe, te);
      else if (k < 15) tagOp("R2 random set", 1, ($urandom_range(0, 4) == 0) ? 8'h91 : 8'h90,
                             a, 4'($urandom_range(1, 13)), pe);
      else if (k < 17) tagOp("R9 random blk", 1, 8'h92, a, 4'($urandom_range(1, 13)), pe);
      else if (k < 19) tagOp("R2 random read", 0, 8'h90, a, 0, 1);
      else             errWb(a);
    end

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL all requirements watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule